// File: doc/BRIEF.md
# Bitstream Header Ratio Selector

This block watches a stream of 32-bit configuration words that arrive ahead of device programming. It numbers each accepted word from the start-of-stream marker onward. From two fixed header positions it picks out whether the image is encrypted and whether it is compressed. From those two flags and the selected configuration bus width it works out the clock-to-data ratio code and the width setting. The programming sequencer must load both before it streams the image.

The stream source pulses `hdr_end` once the header has been delivered. If enough words have arrived, the block publishes the flags, ratio code and width bit, and pulses `done` for one cycle. If too few words have arrived, it raises `size_err` instead and publishes no ratio. Either outcome locks the result until the next start-of-stream marker. The block passes no data through and drives no configuration pins. Full configuration normally runs with the 32-bit width selected.

Top module: `hdr_ratio_sel`

## Requirements
- R1: After reset, `done`, `size_err`, `enc_flag`, `cmp_flag`, `width_bit` and `ratio_code` are all 0.
- R2: If `hdr_end` arrives when fewer than 230 words have been accepted since start-of-stream, `size_err` is 1 in the next cycle. In that case `done` stays 0, and `ratio_code`, `width_bit`, `enc_flag` and `cmp_flag` stay 0. Exactly 230 words is enough.
- R3: `enc_flag` is published as 1 exactly when bits [3:2] of the word at index 69 are not both zero. Indices count from 0 at the first accepted word.
- R4: `cmp_flag` is published as 1 exactly when bit 1 of the word at index 229 is 0. A 1 in that bit means uncompressed.
- R5: `ratio_code` uses the encoding 0 = x1, 1 = x2, 2 = x4, 3 = x8. With `wide_sel` = 0 (16-bit bus), it is 0 for plain, 2 for compressed, 1 for encrypted only and 2 for both.
- R6: With `wide_sel` = 1 (32-bit bus), `ratio_code` is 0 for plain, 3 for compressed, 2 for encrypted only and 3 for both. `width_bit` is published equal to `wide_sel` as sampled at `hdr_end`.
- R7: On a successful `hdr_end`, `done` is 1 for exactly the one following cycle. The flags, ratio and width are updated in that same cycle and held afterwards.
- R8: A cycle with `sos` = 1 clears the word count and all outputs to 0 in the next cycle. A word presented with `word_vld` in that same cycle is not counted.
- R9: After `done` or `size_err`, further words and further `hdr_end` pulses change no output until the next `sos`.
- R10: Words at indices other than 69 and 229 have no effect on the published flags or ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sos | input | 1 | Start-of-stream marker, clears count and result |
| word_vld | input | 1 | A configuration word is present this cycle |
| word_data | input | 32 | Configuration word |
| hdr_end | input | 1 | Header delivered, evaluate now |
| wide_sel | input | 1 | Bus width: 1 = 32-bit, 0 = 16-bit |
| enc_flag | output | 1 | Image is encrypted |
| cmp_flag | output | 1 | Image is compressed |
| ratio_code | output | 2 | Clock-to-data ratio code (0 x1, 1 x2, 2 x4, 3 x8) |
| width_bit | output | 1 | Configuration width setting to load |
| done | output | 1 | One-cycle pulse, result valid |
| size_err | output | 1 | Header too short, sticky until `sos` |

## Verification
The properties assume that `hdr_end` and `sos` are single-cycle pulses. They also assume that `sos` is the only way a new stream begins, so a locked result may change only after an `sos` cycle. The bench keeps to this: every stream opens with one `sos` cycle, words follow with random idle gaps, and `hdr_end` is issued once with no concurrent word. Repeated `hdr_end` pulses after the result has locked are used on purpose to exercise the lock. Beats that coincide with `sos` are applied only in a directed case. In that case the words around the two header indices carry opposite flag values, so an index shift would show at the outputs.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

    typedef enum logic [1:0] {
        RATIO_X1 = 2'd0,
        RATIO_X2 = 2'd1,
        RATIO_X4 = 2'd2,
        RATIO_X8 = 2'd3
    } ratio_e;

    typedef struct packed {
        logic       locked;
        logic       done;
        logic       err;
        logic       enc;
        logic       cmp;
        logic [1:0] ratio;
        logic       width;
    } pub_t;

endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
    parameter int SAT_COUNT = 230,
    localparam int CNT_W = $clog2(SAT_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             beat,
    output logic [CNT_W-1:0] idx_q,
    output logic [CNT_W-1:0] cnt_next
);

    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT_COUNT);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_next = idx_q;
        if (beat && (idx_q != SAT_C)) begin
            cnt_next = idx_q + 1'b1;
        end
        cnt_d = clear ? '0 : cnt_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= cnt_d;
        end
    end

endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
    parameter int WORD_W    = 32,
    parameter int CNT_W     = 8,
    parameter int ENC_IDX   = 69,
    parameter int CMP_IDX   = 229,
    parameter int ENC_LSB   = 2,
    parameter int ENC_WIDTH = 2,
    parameter int CMP_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              beat,
    input  logic [CNT_W-1:0]  idx,
    input  logic [WORD_W-1:0] data,
    output logic              enc_now,
    output logic              cmp_now
);

    localparam logic [CNT_W-1:0] ENC_C = CNT_W'(ENC_IDX);
    localparam logic [CNT_W-1:0] CMP_C = CNT_W'(CMP_IDX);

    logic enc_d, enc_q;
    logic cmp_d, cmp_q;
    logic unused_bits;

    assign unused_bits = ^data;

    always_comb begin
        enc_now = enc_q;
        cmp_now = cmp_q;
        if (beat && (idx == ENC_C)) begin
            enc_now = |data[ENC_LSB +: ENC_WIDTH];
        end
        if (beat && (idx == CMP_C)) begin
            cmp_now = ~data[CMP_BIT];
        end
        enc_d = clear ? 1'b0 : enc_now;
        cmp_d = clear ? 1'b0 : cmp_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q <= 1'b0;
            cmp_q <= 1'b0;
        end else begin
            enc_q <= enc_d;
            cmp_q <= cmp_d;
        end
    end

endmodule

// File: rtl/hdr_ratio_map.sv
module hdr_ratio_map
    import hdr_ratio_pkg::*;
(
    input  logic       enc,
    input  logic       cmp,
    input  logic       wide,
    output logic [1:0] ratio
);

    ratio_e base;

    always_comb begin
        if (cmp) begin
            base = RATIO_X4;
        end else if (enc) begin
            base = RATIO_X2;
        end else begin
            base = RATIO_X1;
        end
        ratio = base;
        if (wide && (enc || cmp)) begin
            ratio = base + 2'd1;
        end
    end

endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
    import hdr_ratio_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MIN_WORDS = 230,
    parameter int ENC_IDX   = 69,
    parameter int CMP_IDX   = 229,
    localparam int CNT_W    = $clog2(MIN_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sos,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    input  logic              hdr_end,
    input  logic              wide_sel,
    output logic              enc_flag,
    output logic              cmp_flag,
    output logic [1:0]        ratio_code,
    output logic              width_bit,
    output logic              done,
    output logic              size_err
);

    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_WORDS);

    logic             beat;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_next;
    logic             enc_now;
    logic             cmp_now;
    logic [1:0]       ratio_now;
    pub_t             pub_d, pub_q;

    assign beat = word_vld && !sos;

    hdr_word_counter #(
        .SAT_COUNT (MIN_WORDS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sos),
        .beat     (beat),
        .idx_q    (idx_q),
        .cnt_next (cnt_next)
    );

    hdr_flag_capture #(
        .WORD_W  (WORD_W),
        .CNT_W   (CNT_W),
        .ENC_IDX (ENC_IDX),
        .CMP_IDX (CMP_IDX)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sos),
        .beat    (beat),
        .idx     (idx_q),
        .data    (word_data),
        .enc_now (enc_now),
        .cmp_now (cmp_now)
    );

    hdr_ratio_map u_map (
        .enc   (enc_now),
        .cmp   (cmp_now),
        .wide  (wide_sel),
        .ratio (ratio_now)
    );

    always_comb begin
        pub_d      = pub_q;
        pub_d.done = 1'b0;
        if (sos) begin
            pub_d = '0;
        end else if (hdr_end && !pub_q.locked) begin
            pub_d.locked = 1'b1;
            if (cnt_next < MIN_C) begin
                pub_d.err = 1'b1;
            end else begin
                pub_d.done  = 1'b1;
                pub_d.enc   = enc_now;
                pub_d.cmp   = cmp_now;
                pub_d.ratio = ratio_now;
                pub_d.width = wide_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pub_q <= '0;
        end else begin
            pub_q <= pub_d;
        end
    end

    assign enc_flag   = pub_q.enc;
    assign cmp_flag   = pub_q.cmp;
    assign ratio_code = pub_q.ratio;
    assign width_bit  = pub_q.width;
    assign done       = pub_q.done;
    assign size_err   = pub_q.err;

endmodule

// File: rtl/hdr_ratio_sel_chk.sv
module hdr_ratio_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sos,
    input logic       hdr_end,
    input logic       enc_flag,
    input logic       cmp_flag,
    input logic [1:0] ratio_code,
    input logic       width_bit,
    input logic       done,
    input logic       size_err
);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(hdr_end) && !$past(sos)));

    p_no_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && size_err));

    p_err_no_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> (ratio_code == 2'd0 && !width_bit));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (size_err && !sos) |=> size_err);

    p_ratio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sos |=> (done || $stable(ratio_code)));

    p_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !enc_flag && !cmp_flag) |-> (ratio_code == 2'd0));

    p_narrow_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !width_bit && cmp_flag) |-> (ratio_code == 2'd2));

    p_wide_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && width_bit && cmp_flag) |-> (ratio_code == 2'd3));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sos |=> (ratio_code == 2'd0 && !done && !size_err && !enc_flag && !cmp_flag));

endmodule

bind hdr_ratio_sel hdr_ratio_sel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sos        (sos),
    .hdr_end    (hdr_end),
    .enc_flag   (enc_flag),
    .cmp_flag   (cmp_flag),
    .ratio_code (ratio_code),
    .width_bit  (width_bit),
    .done       (done),
    .size_err   (size_err)
);

// File: tb/hdr_ratio_sel_test.sv
module hdr_ratio_sel_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sos = 1'b0;
    logic        word_vld = 1'b0;
    logic [31:0] word_data = '0;
    logic        hdr_end = 1'b0;
    logic        wide_sel = 1'b0;
    logic        enc_flag, cmp_flag, width_bit, done, size_err;
    logic [1:0]  ratio_code;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hdr_ratio_sel uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sos        (sos),
        .word_vld   (word_vld),
        .word_data  (word_data),
        .hdr_end    (hdr_end),
        .wide_sel   (wide_sel),
        .enc_flag   (enc_flag),
        .cmp_flag   (cmp_flag),
        .ratio_code (ratio_code),
        .width_bit  (width_bit),
        .done       (done),
        .size_err   (size_err)
    );

    function automatic logic [1:0] exp_ratio(logic e, logic c, logic w);
        logic [1:0] r;
        if (!e && !c) return 2'd0;
        r = c ? 2'd2 : 2'd1;
        if (w) r = r + 2'd1;
        return r;
    endfunction

    task automatic chk(string tag, int got, int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_all(string tag, logic e_enc, logic e_cmp, logic [1:0] e_rat,
                           logic e_w, logic e_done, logic e_err);
        chk({tag, " enc_flag"}, enc_flag, e_enc);
        chk({tag, " cmp_flag"}, cmp_flag, e_cmp);
        chk({tag, " ratio_code"}, ratio_code, e_rat);
        chk({tag, " width_bit"}, width_bit, e_w);
        chk({tag, " done"}, done, e_done);
        chk({tag, " size_err"}, size_err, e_err);
    endtask

    function automatic logic [31:0] make_word(int i, logic [1:0] encb, logic raw_cmp);
        logic [31:0] w = $urandom;
        if (i == 69) w[3:2] = encb;
        if (i == 68 || i == 70) w[3:2] = (encb == 2'b00) ? 2'b11 : 2'b00;
        if (i == 229) w[1] = raw_cmp;
        if (i == 228 || i == 230) w[1] = ~raw_cmp;
        return w;
    endfunction

    // Open a stream, deliver n words with random gaps, then pulse hdr_end.
    // On return the result of hdr_end is visible at the outputs.
    task automatic run_stream(int n, logic [1:0] encb, logic raw_cmp, logic wide, bit sos_beat);
        @(negedge clk);
        sos = 1'b1;
        word_vld = sos_beat;
        word_data = make_word(0, encb, raw_cmp);
        @(negedge clk);
        sos = 1'b0;
        word_vld = 1'b0;
        for (int i = 0; i < n; i++) begin
            word_vld = 1'b1;
            word_data = make_word(i, encb, raw_cmp);
            @(negedge clk);
            word_vld = 1'b0;
            repeat ($urandom_range(2)) @(negedge clk);
        end
        wide_sel = wide;
        hdr_end = 1'b1;
        @(negedge clk);
        hdr_end = 1'b0;
    endtask

    task automatic check_stream(string tag, int n, logic [1:0] encb, logic raw_cmp, logic wide);
        logic e, c;
        e = |encb;
        c = ~raw_cmp;
        if (n >= 230) begin
            chk_all({tag, " R3 R4 R5 R6 R7 result"}, e, c, exp_ratio(e, c, wide), wide, 1'b1, 1'b0);
            @(negedge clk);
            chk_all({tag, " R7 hold"}, e, c, exp_ratio(e, c, wide), wide, 1'b0, 1'b0);
        end else begin
            chk_all({tag, " R2 short"}, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
            @(negedge clk);
            chk_all({tag, " R2 hold"}, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk_all("R1 during reset", 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after reset", 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);

        // Directed: every flag combination on both widths (R5, R6, R10)
        for (int k = 0; k < 8; k++) begin
            logic [1:0] eb;
            eb = k[0] ? 2'(1 + $urandom_range(2)) : 2'b00;
            run_stream(230, eb, ~k[1], k[2], 1'b0);
            check_stream("R5 R6 R10 table", 230, eb, ~k[1], k[2]);
        end

        // Boundary: one word short, and an empty header (R2)
        run_stream(229, 2'b11, 1'b0, 1'b1, 1'b0);
        check_stream("R2 229 words", 229, 2'b11, 1'b0, 1'b1);
        run_stream(0, 2'b00, 1'b1, 1'b0, 1'b0);
        check_stream("R2 zero words", 0, 2'b00, 1'b1, 1'b0);

        // R9: after size_err, more words and hdr_end change nothing
        for (int i = 0; i < 5; i++) begin
            word_vld = 1'b1;
            word_data = $urandom;
            @(negedge clk);
        end
        word_vld = 1'b0;
        hdr_end = 1'b1;
        @(negedge clk);
        hdr_end = 1'b0;
        chk_all("R9 locked after error", 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);

        // R9: after done, another hdr_end with other width changes nothing
        run_stream(235, 2'b01, 1'b1, 1'b0, 1'b0);
        check_stream("R9 setup", 235, 2'b01, 1'b1, 1'b0);
        wide_sel = 1'b1;
        hdr_end = 1'b1;
        @(negedge clk);
        hdr_end = 1'b0;
        chk_all("R9 locked after done", 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0);

        // R8: sos clears outputs
        sos = 1'b1;
        @(negedge clk);
        sos = 1'b0;
        chk_all("R8 clear", 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);

        // R8: beat during sos is not counted (neighbours carry opposite flags)
        run_stream(230, 2'b00, 1'b1, 1'b1, 1'b1);
        check_stream("R8 sos beat dropped", 230, 2'b00, 1'b1, 1'b1);

        // Constrained random streams
        for (int s = 0; s < 24; s++) begin
            int n;
            logic [1:0] eb;
            logic rc, w;
            n = ($urandom_range(4) == 0) ? $urandom_range(229) : 230 + $urandom_range(10);
            eb = 2'($urandom);
            rc = 1'($urandom);
            w = 1'($urandom);
            run_stream(n, eb, rc, w, 1'b0);
            check_stream("R3 R4 R10 random", n, eb, rc, w);
        end

        summary();
        $finish;
    end

endmodule